// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup with Colour Alias Handling

This block is the tag and lookup path of a 32 KB, 4-way cache with 32-byte lines. The set is chosen from virtual address bits, so the tag read begins as soon as a request is accepted. The matching physical page number comes from a translation port one cycle later. Each way holds 8 KB, which is twice the 4 KB page. The top set-index bit (virtual bit 12) is therefore a page-colour bit that translation does not fix. One physical line can thus sit in two sets that differ only in that bit.

On a primary miss, the block spends one more cycle reading the set of the opposite colour. If the same physical tag is valid there, it has found an alias. It then does one of two things, chosen by a mode input. It can flush the duplicate: a dirty copy is written back first, and the copy is then invalidated. Or it can keep the duplicate and only flag it in the response. After that it picks a victim in the requested set, writes that victim back if it is dirty, and requests a fill of the new line. A synchronous invalidate-all walks every set once. The data array, the translation buffer and coherency are outside this block.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is `req_vset`, which carries virtual address bits 12:5. Bit 7 of `req_vset` (virtual bit 12) is the colour bit. The stored tag is the 20-bit physical page number (physical bits 31:12). Every line address on the fill and evict ports is {tag, set[6:0], 5'b0}.
- R2: After reset every line is invalid and every replacement state is 0. `req_ready` is 1, and `rsp_valid`, `evict_valid` and `fill_valid` are 0.
- R3: A request is accepted in cycle t. `xlat_ppn` is sampled in cycle t+1. If a valid way of the set holds that tag, `rsp_valid` pulses in cycle t+2 with `rsp_hit`=1, the way number on `rsp_way` and `rsp_alias`=0. A write hit marks the line dirty. No fill or evict is requested on a hit.
- R4: Two requests with the same physical page and the same colour bit use the same set. The second request hits and reports no alias.
- R5: On a miss, the set whose colour bit is inverted is probed for the same tag. `rsp_alias` reports whether a valid copy was found there.
- R6: When `alias_flush`=1 and an alias is found, the duplicate is invalidated. If it is dirty, it is first written back on the evict port, at its own line address. A later request to that duplicate's set misses.
- R7: When `alias_flush`=0, an alias is only reported. The duplicate stays valid, is not written back, and a later request to it hits.
- R8: On a miss, the victim is the lowest-numbered invalid way. If all ways are valid, the victim comes from a 3-bit tree state. If t[0]=0 the victim is way t[1]; if t[0]=1 it is way 2+t[2]. Every hit and every fill on way w sets t[0]=~w[1], and then t[1]=~w[0] when w<2, or t[2]=~w[0] otherwise.
- R9: A victim that is valid and dirty is written back on the evict port before the fill. A clean victim produces no evict. When both happen, the alias write-back comes before the victim write-back.
- R10: A fill is requested with `fill_valid`=1 and the new line's address. On acceptance the line is installed valid, dirty when the request was a write, in the victim way. `rsp_valid` then pulses with `rsp_hit`=0 and `rsp_way` set to that way.
- R11: If `inv_all` is 1 while the block is idle, it wins over `req_valid`. `req_ready` then stays 0 for exactly 256 cycles. Afterwards every line is invalid and every replacement state is 0, and dirty lines are dropped without any evict.
- R12: `evict_valid` and `evict_addr`, and likewise `fill_valid` and `fill_addr`, hold steady until the matching ready is seen. Evict and fill are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alias_flush | input | 1 | 1: flush alias duplicates, 0: report only |
| inv_all | input | 1 | Invalidate every line (taken when idle) |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vset | input | 8 | Virtual address bits 12:5 |
| req_write | input | 1 | Request is a store |
| xlat_ppn | input | 20 | Physical page number, valid the cycle after acceptance |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Request hit in its own set |
| rsp_way | output | 2 | Way that holds the line |
| rsp_alias | output | 1 | Copy found in the opposite-colour set |
| evict_valid | output | 1 | Write-back request |
| evict_ready | input | 1 | Write-back accepted |
| evict_addr | output | 32 | Physical line address to write back |
| fill_valid | output | 1 | Line fill request |
| fill_ready | input | 1 | Fill accepted |
| fill_addr | output | 32 | Physical line address to fetch |

## Verification
A corrupted tag, valid or dirty bit does not show up at once. It appears on the next request that touches the set or its opposite-colour twin. The symptoms are a wrong hit or miss, a wrong way, an alias flag that is present or missing, or a write-back that is missing, extra or at the wrong address. Those requests are the ones that expose it. A corrupted tree state appears only when a full set next evicts, as a different `rsp_way` and victim address. The bench therefore mixes random requests over a small pool of sets and pages, so that faults surface within a few requests.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int PA_W        = 32;
    localparam int PAGE_BITS   = 12;
    localparam int LINE_BITS   = 5;
    localparam int COLOUR_BITS = 1;
    localparam int WAYS        = 4;   // tree replacement below assumes 4

    localparam int TAG_W       = PA_W - PAGE_BITS;
    localparam int SET_BITS    = PAGE_BITS + COLOUR_BITS - LINE_BITS;
    localparam int SETS        = 1 << SET_BITS;
    localparam int INPAGE_BITS = PAGE_BITS - LINE_BITS;
    localparam int WAY_W       = $clog2(WAYS);
    localparam int PLRU_W      = WAYS - 1;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [SET_BITS-1:0] set_t;
    typedef logic [WAY_W-1:0]    way_t;
    typedef logic [PLRU_W-1:0]   plru_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        tag_t tag;
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PROBE,
        ST_AEVICT,
        ST_VICTIM,
        ST_VEVICT,
        ST_FILL,
        ST_CLEAR
    } state_t;

    function automatic way_t plru_pick(input plru_t t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    function automatic plru_t plru_touch(input plru_t t, input way_t w);
        plru_t r;
        r    = t;
        r[0] = ~w[1];
        if (w[1]) r[2] = ~w[0];
        else      r[1] = ~w[0];
        return r;
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  set_t                  rd_set,
    output line_t [WAYS-1:0]      rd_lines,
    output plru_t                 rd_plru,
    input  logic                  wr_en,
    input  set_t                  wr_set,
    input  way_t                  wr_way,
    input  line_t                 wr_line,
    input  logic                  lru_en,
    input  set_t                  lru_set,
    input  plru_t                 lru_val,
    input  logic                  clr_en,
    input  set_t                  clr_set
);

    line_t [WAYS-1:0] mem [SETS];
    plru_t            lru [SETS];

    assign rd_lines = mem[rd_set];
    assign rd_plru  = lru[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s] <= '0;
                lru[s] <= '0;
            end
        end else begin
            if (clr_en) begin
                mem[clr_set] <= '0;
                lru[clr_set] <= '0;
            end
            if (wr_en)  mem[wr_set][wr_way] <= wr_line;
            if (lru_en) lru[lru_set] <= lru_val;
        end
    end

    // clearing walk never overlaps an update (R11)
    assert_clear_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> !(wr_en || lru_en));

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match
    import vipt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  line_t [WAYS-1:0] lines,
    input  tag_t             key,
    output logic             hit,
    output way_t             hit_way,
    output logic             any_free,
    output way_t             free_way
);

    logic [WAYS-1:0] hv;
    logic [WAYS-1:0] fv;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hv[g] = lines[g].valid && (lines[g].tag == key);
        assign fv[g] = !lines[g].valid;
    end

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hv[i]) hit_way  = way_t'(i);
            if (fv[i]) free_way = way_t'(i);
        end
    end

    assign hit      = |hv;
    assign any_free = |fv;

    // a physical line is held at most once inside one set (R3)
    assert_single_copy_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hv));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alias_flush,
    input  logic                 inv_all,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SET_BITS-1:0]  req_vset,
    input  logic                 req_write,
    input  logic [TAG_W-1:0]     xlat_ppn,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WAY_W-1:0]     rsp_way,
    output logic                 rsp_alias,
    output logic                 evict_valid,
    input  logic                 evict_ready,
    output logic [PA_W-1:0]      evict_addr,
    output logic                 fill_valid,
    input  logic                 fill_ready,
    output logic [PA_W-1:0]      fill_addr
);

    localparam set_t COLOUR_MASK = {1'b1, {(SET_BITS-1){1'b0}}};

    state_t state;
    set_t   cur_set, clr_cnt;
    logic   cur_wr, alias_hit;
    tag_t   cur_ppn, vic_tag;
    way_t   alias_way, vic_way;

    set_t             rd_set;
    line_t [WAYS-1:0] rd_lines;
    plru_t            rd_plru;
    tag_t             key;
    logic             m_hit, m_free;
    way_t             m_way, m_free_way, vic_pick;

    logic  wr_en, lru_en, clr_en;
    set_t  wr_set;
    way_t  wr_way;
    line_t wr_line;
    plru_t lru_val;

    assign rd_set   = (state == ST_PROBE || state == ST_AEVICT) ? (cur_set ^ COLOUR_MASK) : cur_set;
    assign key      = (state == ST_LOOK) ? xlat_ppn : cur_ppn;
    assign vic_pick = m_free ? m_free_way : plru_pick(rd_plru);

    vipt_tag_store store_i (
        .clk(clk), .rst(rst),
        .rd_set(rd_set), .rd_lines(rd_lines), .rd_plru(rd_plru),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_line(wr_line),
        .lru_en(lru_en), .lru_set(cur_set), .lru_val(lru_val),
        .clr_en(clr_en), .clr_set(clr_cnt)
    );

    vipt_way_match match_i (
        .clk(clk), .rst(rst),
        .lines(rd_lines), .key(key),
        .hit(m_hit), .hit_way(m_way),
        .any_free(m_free), .free_way(m_free_way)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_set  = cur_set;
        wr_way  = m_way;
        wr_line = '0;
        lru_en  = 1'b0;
        lru_val = plru_touch(rd_plru, m_way);
        clr_en  = (state == ST_CLEAR);
        unique case (state)
            ST_LOOK: if (m_hit) begin
                lru_en = 1'b1;
                if (cur_wr) begin
                    wr_en         = 1'b1;
                    wr_line       = rd_lines[m_way];
                    wr_line.dirty = 1'b1;
                end
            end
            ST_PROBE: if (m_hit && alias_flush && !rd_lines[m_way].dirty) begin
                wr_en  = 1'b1;
                wr_set = rd_set;
            end
            ST_AEVICT: if (evict_ready) begin
                wr_en  = 1'b1;
                wr_set = rd_set;
                wr_way = alias_way;
            end
            ST_FILL: if (fill_ready) begin
                wr_en   = 1'b1;
                wr_way  = vic_way;
                wr_line = '{valid: 1'b1, dirty: cur_wr, tag: cur_ppn};
                lru_en  = 1'b1;
                lru_val = plru_touch(rd_plru, vic_way);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_set   <= '0;
            clr_cnt   <= '0;
            cur_wr    <= 1'b0;
            cur_ppn   <= '0;
            vic_tag   <= '0;
            vic_way   <= '0;
            alias_way <= '0;
            alias_hit <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_alias <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (inv_all) begin
                        state   <= ST_CLEAR;
                        clr_cnt <= '0;
                    end else if (req_valid) begin
                        cur_set <= req_vset;
                        cur_wr  <= req_write;
                        state   <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    cur_ppn   <= xlat_ppn;
                    alias_hit <= 1'b0;
                    if (m_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_way   <= m_way;
                        rsp_alias <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_PROBE;
                    end
                end
                ST_PROBE: begin
                    alias_hit <= m_hit;
                    alias_way <= m_way;
                    if (m_hit && alias_flush && rd_lines[m_way].dirty) state <= ST_AEVICT;
                    else                                               state <= ST_VICTIM;
                end
                ST_AEVICT: if (evict_ready) state <= ST_VICTIM;
                ST_VICTIM: begin
                    vic_way <= vic_pick;
                    vic_tag <= rd_lines[vic_pick].tag;
                    if (rd_lines[vic_pick].valid && rd_lines[vic_pick].dirty) state <= ST_VEVICT;
                    else                                                        state <= ST_FILL;
                end
                ST_VEVICT: if (evict_ready) state <= ST_FILL;
                ST_FILL: if (fill_ready) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b0;
                    rsp_way   <= vic_way;
                    rsp_alias <= alias_hit;
                    state     <= ST_IDLE;
                end
                ST_CLEAR: begin
                    clr_cnt <= clr_cnt + 1'b1;
                    if (&clr_cnt) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state == ST_IDLE) && !inv_all;
    assign evict_valid = (state == ST_AEVICT) || (state == ST_VEVICT);
    assign evict_addr  = {(state == ST_AEVICT) ? cur_ppn : vic_tag,
                          cur_set[INPAGE_BITS-1:0], {LINE_BITS{1'b0}}};
    assign fill_valid  = (state == ST_FILL);
    assign fill_addr   = {cur_ppn, cur_set[INPAGE_BITS-1:0], {LINE_BITS{1'b0}}};

    // response is a single-cycle pulse (R3)
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // write-back request holds until taken (R12)
    assert_evict_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_addr)));

    // fill request holds until taken (R10)
    assert_fill_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));

    // no new request is taken while a response is outstanding (R3)
    assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (evict_valid || fill_valid) |-> !req_ready);

endmodule

// File: tb/vipt_lookup_tb_top.sv
module vipt_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        alias_flush;
    logic        inv_all;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_vset;
    logic        req_write;
    logic [19:0] xlat_ppn;
    logic        rsp_valid, rsp_hit, rsp_alias;
    logic [1:0]  rsp_way;
    logic        evict_valid, evict_ready, fill_valid, fill_ready;
    logic [31:0] evict_addr, fill_addr;

    always #5 clk = ~clk;

    vipt_lookup dut_i (
        .clk(clk), .rst(rst), .alias_flush(alias_flush), .inv_all(inv_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_vset(req_vset),
        .req_write(req_write), .xlat_ppn(xlat_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_alias(rsp_alias),
        .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_addr(evict_addr),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit          mv [256][4];
    bit          md [256][4];
    logic [19:0] mt [256][4];
    logic [2:0]  ml [256];

    // last observed results
    logic        last_hit, last_alias;
    logic [1:0]  last_way;
    int          last_nev;
    logic [31:0] last_ev0;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_victim(input logic [2:0] t);
        if (t[0] == 1'b0) return t[1] ? 2'd1 : 2'd0;
        return t[2] ? 2'd3 : 2'd2;
    endfunction

    task automatic ref_touch(input int s, input logic [1:0] w);
        ml[s][0] = ~w[1];
        if (w < 2) ml[s][1] = ~w[0];
        else       ml[s][2] = ~w[0];
    endtask

    function automatic logic [31:0] line_addr(input logic [19:0] p, input logic [7:0] s);
        return {p, s[6:0], 5'b00000};
    endfunction

    task automatic do_req(input logic [7:0] s, input logic [19:0] p, input logic w);
        logic        e_hit, e_alias, got, got_fill, both;
        logic [1:0]  e_way;
        logic [31:0] e_ev [2];
        logic [31:0] o_ev [2];
        logic [31:0] e_fill, o_fill;
        int          e_nev, n_ev, lat, aw, v;
        logic [7:0]  a;
        e_hit = 0; e_alias = 0; e_way = 0; e_nev = 0; e_fill = 0;
        e_ev[0] = 0; e_ev[1] = 0; o_ev[0] = 0; o_ev[1] = 0; o_fill = 0;
        for (int i = 0; i < 4; i++)
            if (!e_hit && mv[s][i] && mt[s][i] == p) begin e_hit = 1; e_way = 2'(i); end
        if (e_hit) begin
            ref_touch(s, e_way);
            if (w) md[s][e_way] = 1;
        end else begin
            a  = s ^ 8'h80;
            aw = -1;
            for (int i = 0; i < 4; i++)
                if (aw < 0 && mv[a][i] && mt[a][i] == p) aw = i;
            e_alias = (aw >= 0);
            if (e_alias && alias_flush) begin
                if (md[a][aw]) begin e_ev[e_nev] = line_addr(p, s); e_nev++; end
                mv[a][aw] = 0; md[a][aw] = 0;
            end
            v = -1;
            for (int i = 0; i < 4; i++) if (v < 0 && !mv[s][i]) v = i;
            if (v < 0) v = int'(ref_victim(ml[s]));
            if (mv[s][v] && md[s][v]) begin e_ev[e_nev] = line_addr(mt[s][v], s); e_nev++; end
            mv[s][v] = 1; md[s][v] = w; mt[s][v] = p;
            ref_touch(s, 2'(v));
            e_way  = 2'(v);
            e_fill = line_addr(p, s);
        end

        while (!req_ready) @(negedge clk);
        req_valid = 1; req_vset = s; req_write = w;
        @(negedge clk);
        req_valid = 0; xlat_ppn = p;
        got = 0; got_fill = 0; both = 0; n_ev = 0; lat = 0;
        for (int c = 0; c < 80 && !got; c++) begin
            @(negedge clk);
            lat++;
            if (evict_valid && fill_valid) both = 1;
            if (rsp_valid) begin
                got = 1;
            end else begin
                evict_ready = ($urandom % 3) != 0;
                fill_ready  = ($urandom % 3) != 0;
                if (evict_valid && evict_ready) begin
                    if (n_ev < 2) o_ev[n_ev] = evict_addr;
                    n_ev++;
                end
                if (fill_valid && fill_ready) begin got_fill = 1; o_fill = fill_addr; end
            end
        end
        evict_ready = 0; fill_ready = 0;

        chk("R3", "response seen", 64'(got), 64'd1);
        chk("R3", "hit flag", 64'(rsp_hit), 64'(e_hit));
        chk("R8", "way", 64'(rsp_way), 64'(e_way));
        chk("R5", "alias flag", 64'(rsp_alias), 64'(e_alias));
        chk("R9", "writeback count", 64'(n_ev), 64'(e_nev));
        chk("R12", "evict and fill overlap", 64'(both), 64'd0);
        for (int k = 0; k < 2; k++)
            if (k < e_nev) chk("R9", "writeback address", 64'(o_ev[k]), 64'(e_ev[k]));
        if (e_hit) begin
            chk("R3", "hit latency", 64'(lat), 64'd1);
            chk("R3", "no fill on hit", 64'(got_fill), 64'd0);
        end else begin
            chk("R10", "fill issued", 64'(got_fill), 64'd1);
            chk("R1", "fill address", 64'(o_fill), 64'(e_fill));
        end
        last_hit = rsp_hit; last_alias = rsp_alias; last_way = rsp_way;
        last_nev = n_ev; last_ev0 = o_ev[0];
    endtask

    task automatic do_clear();
        int n;
        while (!req_ready) @(negedge clk);
        inv_all = 1; req_valid = 1; req_vset = 8'h10; xlat_ppn = 20'h0;
        @(negedge clk);
        inv_all = 0; req_valid = 0;
        n = 0;
        while (!req_ready && n < 400) begin n++; @(negedge clk); end
        chk("R11", "not-ready cycles", 64'(n), 64'd256);
        chk("R11", "no write-back during clear", 64'(evict_valid), 64'd0);
        for (int s = 0; s < 256; s++) begin
            ml[s] = 0;
            for (int i = 0; i < 4; i++) begin mv[s][i] = 0; md[s][i] = 0; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  set_pool [6];
        logic [19:0] ppn_pool [6];
        void'($urandom(32'd4242));
        for (int s = 0; s < 256; s++) begin
            ml[s] = 0;
            for (int i = 0; i < 4; i++) begin mv[s][i] = 0; md[s][i] = 0; mt[s][i] = 0; end
        end
        rst = 1; alias_flush = 1; inv_all = 0; req_valid = 0; req_vset = 0;
        req_write = 0; xlat_ppn = 0; evict_ready = 0; fill_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R2", "req_ready after reset", 64'(req_ready), 64'd1);
        chk("R2", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R2", "evict_valid after reset", 64'(evict_valid), 64'd0);
        chk("R2", "fill_valid after reset", 64'(fill_valid), 64'd0);

        // cold miss, then hits
        do_req(8'h05, 20'h12345, 0);
        chk("R10", "cold miss way", 64'(last_way), 64'd0);
        do_req(8'h05, 20'h12345, 0);
        chk("R4", "same colour same page hits", 64'(last_hit), 64'd1);
        chk("R4", "same colour no alias", 64'(last_alias), 64'd0);
        do_req(8'h05, 20'h12345, 1);

        // dirty alias under the other colour: flushed with write-back
        do_req(8'h85, 20'h12345, 0);
        chk("R6", "dirty alias written back", 64'(last_nev), 64'd1);
        chk("R6", "alias write-back address", 64'(last_ev0), 64'({20'h12345, 7'h05, 5'h0}));
        // clean alias back the other way: no write-back, original copy gone
        do_req(8'h05, 20'h12345, 0);
        chk("R6", "flushed copy misses", 64'(last_hit), 64'd0);
        chk("R6", "clean alias no write-back", 64'(last_nev), 64'd0);

        // replacement in a full set
        for (int k = 0; k < 4; k++) do_req(8'h10, 20'hA0000 + 20'(k), 1);
        do_req(8'h10, 20'hA0004, 1);
        chk("R8", "tree victim after four fills", 64'(last_way), 64'd0);
        chk("R9", "dirty victim address", 64'(last_ev0), 64'({20'hA0000, 7'h10, 5'h0}));
        do_req(8'h10, 20'hA0001, 0);
        do_req(8'h10, 20'hA0005, 0);
        chk("R8", "tree victim after hit on way 1", 64'(last_way), 64'd2);

        // report-only mode
        alias_flush = 0;
        do_req(8'h90, 20'hA0003, 0);
        chk("R7", "alias reported", 64'(last_alias), 64'd1);
        chk("R7", "no write-back in report mode", 64'(last_nev), 64'd0);
        do_req(8'h10, 20'hA0003, 0);
        chk("R7", "duplicate kept", 64'(last_hit), 64'd1);

        // invalidate all, dirty lines dropped
        do_clear();
        do_req(8'h10, 20'hA0003, 0);
        chk("R11", "line gone after clear", 64'(last_hit), 64'd0);
        chk("R11", "no alias after clear", 64'(last_alias), 64'd0);
        chk("R11", "fill into way 0 after clear", 64'(last_way), 64'd0);

        // random mix over a small pool
        set_pool[0] = 8'h05; set_pool[1] = 8'h85; set_pool[2] = 8'h10;
        set_pool[3] = 8'h90; set_pool[4] = 8'h33; set_pool[5] = 8'hB3;
        for (int k = 0; k < 6; k++) ppn_pool[k] = 20'h40000 + 20'(k * 17);
        for (int n = 0; n < 400; n++) begin
            alias_flush = ($urandom % 3) != 0;
            do_req(set_pool[$urandom % 6], ppn_pool[$urandom % 6], 1'($urandom % 2));
            if (n == 200) do_clear();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule